// File: doc/BRIEF.md
# Security-Banked Distributor Control Register

This block holds the top-level control word of an interrupt distributor: the three group enables, two affinity-routing enables, a bit that collapses the two security states into one, and a write-pending flag. Every access carries a secure attribute. That attribute, together with the single-security bit, decides which bits a write may change and which bits a read can see.

A non-secure agent sees a reduced view of the register and may change only the non-secure group-1 enable. A secure agent may also change the other enables and set the single-security bit. Setting that bit is a one-way step. In the same update it clears the secure group-1 enable and the non-secure routing enable, and after that only reset returns the bit to zero. The three group enables and the single-security state are driven out to the rest of the interrupt logic, and they change on the same clock edge as the write.

The write-pending flag always reads zero here, because every write takes effect in a single cycle. Reads are combinational, and the view returned follows `sec_i` in the same cycle.

Top module: `dist_ctl_reg`

## Requirements
- R1: After reset the stored word is 0x30: bits 4 and 5 are set, and all enables, bit 6 (single-security) and bit 31 (write-pending) are 0. All four outputs are low.
- R2: With bit 6 clear, a secure write (`sec_i`=1) updates bits 0, 1, 2 and 6 from `wdata_i`. No other stored bit changes.
- R3: With bit 6 clear, a non-secure write (`sec_i`=0) changes only bit 1. Bits 0, 2 and 6 keep their values.
- R4: With bit 6 clear, a non-secure read returns only stored bits 31, 4 and 1, and every other bit reads 0. A secure read returns the whole stored word.
- R5: Bits 4 and 5 read as one and ignore writes while bit 6 is clear. Bit 7 and the other unassigned bits read 0 and ignore writes.
- R6: A write that sets bit 6 clears bits 2 and 5 in the same update.
- R7: With bit 6 set, a write of either security changes only bits 0 and 1. Bit 6 stays set, bit 2 stays clear, and reads of either security return the whole word.
- R8: `grp0_en_o`, `grp1ns_en_o` and `grp1s_en_o` follow stored bits 0, 1 and 2, and `sec_dis_o` follows bit 6. Each changes on the clock edge that performs the write, and holds when no write occurs.
- R9: Once bit 6 is set, it returns to 0 only through reset, which restores 0x30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| sec_i | input | 1 | Secure attribute of the current read or write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read view of the register for the current `sec_i` |
| grp0_en_o | output | 1 | Group-0 enable |
| grp1ns_en_o | output | 1 | Non-secure group-1 enable |
| grp1s_en_o | output | 1 | Secure group-1 enable |
| sec_dis_o | output | 1 | Single-security mode active |

## Verification
The hardest state to reach is the one after the one-way transition. There, bit 5 has been cleared, bit 2 can no longer be set, and a non-secure read suddenly sees the full word. The only way into that state is a secure write with bit 6 set, so the stimulus first loads every enable, then sets bit 6 with bits 2 and 5 still high to show that they clear in the same edge. It then tries writes of both security states that would clear bit 6 or set bit 2, and finally resets to leave that mode.

// File: rtl/dist_ctl_pkg.sv
package dist_ctl_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned B_G0    = 0;
  localparam int unsigned B_G1NS  = 1;
  localparam int unsigned B_G1S   = 2;
  localparam int unsigned B_RTS   = 4;
  localparam int unsigned B_RTNS  = 5;
  localparam int unsigned B_SDIS  = 6;
  localparam int unsigned B_WKUP  = 7;
  localparam int unsigned B_WPEND = 31;

  localparam logic [DW-1:0] RST_VAL  = (DW'(1) << B_RTS) | (DW'(1) << B_RTNS);
  localparam logic [DW-1:0] M_SDIS   = (DW'(1) << B_G0) | (DW'(1) << B_G1NS);
  localparam logic [DW-1:0] M_SEC    = M_SDIS | (DW'(1) << B_G1S) | (DW'(1) << B_SDIS);
  localparam logic [DW-1:0] M_NSEC   = DW'(1) << B_G1NS;
  localparam logic [DW-1:0] M_NSVIEW = (DW'(1) << B_WPEND) | (DW'(1) << B_RTS) | (DW'(1) << B_G1NS);
  localparam logic [DW-1:0] M_DROP   = (DW'(1) << B_G1S) | (DW'(1) << B_RTNS);
endpackage

// File: rtl/dist_ctl_wmask.sv
module dist_ctl_wmask
  import dist_ctl_pkg::*;
(
  input  logic          sdis_i,
  input  logic          sec_i,
  output logic [DW-1:0] mask_o
);
  always_comb begin
    if (sdis_i)     mask_o = M_SDIS;
    else if (sec_i) mask_o = M_SEC;
    else            mask_o = M_NSEC;
  end
endmodule

// File: rtl/dist_ctl_rview.sv
module dist_ctl_rview
  import dist_ctl_pkg::*;
(
  input  logic [DW-1:0] ctl_i,
  input  logic          sec_i,
  output logic [DW-1:0] rdata_o
);
  // reduced view only while both security states exist
  always_comb begin
    if (!sec_i && !ctl_i[B_SDIS]) rdata_o = ctl_i & M_NSVIEW;
    else                          rdata_o = ctl_i;
  end
endmodule

// File: rtl/dist_ctl_reg.sv
module dist_ctl_reg
  import dist_ctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          sec_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          grp0_en_o,
  output logic          grp1ns_en_o,
  output logic          grp1s_en_o,
  output logic          sec_dis_o
);
  logic [DW-1:0] ctl_q, ctl_d, wmask, wbits;

  dist_ctl_wmask u_wmask (
    .sdis_i (ctl_q[B_SDIS]),
    .sec_i  (sec_i),
    .mask_o (wmask)
  );

  assign wbits = wdata_i & wmask;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en_i) begin
      ctl_d = (ctl_q & ~wmask) | wbits;
      if (wbits[B_SDIS]) ctl_d = ctl_d & ~M_DROP;  // one-way collapse
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= RST_VAL;
    else         ctl_q <= ctl_d;
  end

  dist_ctl_rview u_rview (
    .ctl_i   (ctl_q),
    .sec_i   (sec_i),
    .rdata_o (rdata_o)
  );

  assign grp0_en_o   = ctl_q[B_G0];
  assign grp1ns_en_o = ctl_q[B_G1NS];
  assign grp1s_en_o  = ctl_q[B_G1S];
  assign sec_dis_o   = ctl_q[B_SDIS];
endmodule

// File: rtl/dist_ctl_chk.sv
module dist_ctl_chk
  import dist_ctl_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          sec_i,
  input logic [DW-1:0] rdata_o,
  input logic          grp0_en_o,
  input logic          grp1ns_en_o,
  input logic          grp1s_en_o,
  input logic          sec_dis_o
);
  // R3
  ns_write_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sec_i && !sec_dis_o) |=> ($stable(grp0_en_o) && $stable(grp1s_en_o) && !sec_dis_o));

  // R4
  ns_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_i && !sec_dis_o) |-> ((rdata_o & ~M_NSVIEW) == '0));

  // R5
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[B_WKUP] == 1'b0) && (rdata_o[B_WPEND] == 1'b0) && (sec_i -> rdata_o[B_RTS]));

  // R6
  collapse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_dis_o) |-> (!grp1s_en_o && (!sec_i -> !rdata_o[B_RTNS])));

  // R7
  sdis_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_dis_o |=> (sec_dis_o && !grp1s_en_o));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(grp0_en_o) && $stable(grp1ns_en_o) && $stable(grp1s_en_o) && $stable(sec_dis_o)));
endmodule

bind dist_ctl_reg dist_ctl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .sec_i       (sec_i),
  .rdata_o     (rdata_o),
  .grp0_en_o   (grp0_en_o),
  .grp1ns_en_o (grp1ns_en_o),
  .grp1s_en_o  (grp1s_en_o),
  .sec_dis_o   (sec_dis_o)
);

// File: tb/sim_dist_ctl_reg.sv
module sim_dist_ctl_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        sec_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        grp0_en_o, grp1ns_en_o, grp1s_en_o, sec_dis_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  dist_ctl_reg u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .sec_i(sec_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .grp0_en_o(grp0_en_o),
    .grp1ns_en_o(grp1ns_en_o), .grp1s_en_o(grp1s_en_o), .sec_dis_o(sec_dis_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(bit sec, logic [31:0] d);
    @(negedge clk_i);
    sec_i = sec; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(bit sec, output logic [31:0] d);
    sec_i = sec;
    #1;
    d = rdata_o;
  endtask

  function automatic logic [31:0] outs();
    return {28'd0, sec_dis_o, grp1s_en_o, grp1ns_en_o, grp0_en_o};
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    do_reset();
    rd(1, r);  chk("R1 secure read", r, 32'h30);
    chk("R1 outputs", outs(), 32'h0);
  endtask

  task automatic t_secure_write();
    logic [31:0] r;
    wr(1, 32'h0000_0007);
    rd(1, r);  chk("R2 secure write enables", r, 32'h37);
    chk("R8 outputs follow", outs(), 32'h7);
    wr(1, 32'hFFFF_FF88);  // touches no writable bit except none of 0..2,6
    rd(1, r);  chk("R5 fixed bits ignore writes", r, 32'h30);
    chk("R2 enables cleared", outs(), 32'h0);
  endtask

  task automatic t_nonsecure();
    logic [31:0] r;
    wr(1, 32'h0000_0005);
    wr(0, 32'hFFFF_FFFF);
    rd(1, r);  chk("R3 ns write only bit1", r, 32'h37);
    wr(0, 32'h0000_0000);
    rd(1, r);  chk("R3 ns clears bit1 only", r, 32'h35);
    rd(0, r);  chk("R4 ns view", r, 32'h10);
    wr(0, 32'h0000_0002);
    rd(0, r);  chk("R4 ns view bit1", r, 32'h12);
    chk("R8 outputs after ns write", outs(), 32'h7);
  endtask

  task automatic t_collapse();
    logic [31:0] r;
    wr(1, 32'h0000_0047);
    rd(1, r);  chk("R6 bits 2 and 5 cleared", r, 32'h53);
    chk("R8 sec_dis and enables", outs(), 32'hB);
    rd(0, r);  chk("R7 ns full view", r, 32'h53);
    wr(1, 32'h0000_0004);
    rd(1, r);  chk("R7 secure write limited", r, 32'h50);
    wr(0, 32'h0000_0027);
    rd(0, r);  chk("R7 ns write bits 0,1", r, 32'h53);
    chk("R9 bit6 sticky", outs(), 32'hB);
  endtask

  task automatic t_rereset();
    logic [31:0] r;
    do_reset();
    rd(1, r);  chk("R9 reset restores", r, 32'h30);
    chk("R9 outputs after reset", outs(), 32'h0);
  endtask

  initial begin
    t_reset();
    t_secure_write();
    t_nonsecure();
    t_collapse();
    t_rereset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule